// File: doc/BRIEF.md
# Phase-Detector Digital Lock Monitor

This block watches the up and down pulses of a phase-frequency detector and decides whether the loop is locked. It runs on a fast sampling clock. During each comparison cycle it counts the sampling ticks on which the up and down pulses disagree. That count is the phase error of the cycle, in ticks. A strobe from the reference side marks the last tick of each comparison cycle, and the block judges the cycle on that tick.

The lock flag is active high and has hysteresis. It sets only after a programmable run of consecutive small-error cycles. The run is three cycles in normal precision and five in high precision. Once high, the flag falls only when one cycle shows an error larger than a second, looser threshold. Errors between the two thresholds break a run in progress but leave an established lock alone.

Both thresholds are inputs in sampling-clock ticks, so the same block serves any ratio of sampling clock to comparison frequency. The set threshold should not exceed the clear threshold plus one. A power-down input forces the monitor back to its unlocked, empty state.

Top module: `pfd_lock_monitor`

## Requirements
- R1: After reset the lock flag is 0. A power-down tick forces the flag to 0 on the next clock. It also empties the good-cycle run and the error accumulator, so a full new run is needed afterwards.
- R2: The error of a cycle is the number of sampling ticks on which up and down differ. Counting starts on the tick after the previous strobe and ends on the strobe tick itself. Ticks with both pulses high, or both low, add nothing.
- R3: A cycle is good when its error is strictly below `setThresh`. A good cycle extends the consecutive-good run by one.
- R4: With `precSel` = 0, the flag rises on the strobe tick of the third consecutive good cycle. It is visible one clock after that strobe edge.
- R5: With `precSel` = 1, the flag rises on the strobe tick of the fifth consecutive good cycle.
- R6: A cycle that is not good resets the run to zero. A run interrupted by such a cycle, including an error exactly equal to `setThresh`, does not set the flag.
- R7: While the flag is high, one cycle with error strictly above `clrThresh` clears it on that cycle's strobe tick.
- R8: While the flag is high, a cycle with error from `setThresh` up to and including `clrThresh` leaves the flag high.
- R9: The run counter saturates and does not wrap. Any number of good cycles keeps the flag high.
- R10: The flag changes only on a strobe tick or a power-down tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrDown | input | 1 | Synchronous power-down; clears the monitor |
| upPulse | input | 1 | Up pulse from the phase detector |
| dnPulse | input | 1 | Down pulse from the phase detector |
| cycleStrobe | input | 1 | High on the last sampling tick of each comparison cycle |
| precSel | input | 1 | 0: three good cycles to lock; 1: five |
| setThresh | input | CNT_W | Error in ticks below which a cycle is good |
| clrThresh | input | CNT_W | Error in ticks above which a locked flag clears |
| lockFlag | output | 1 | Active-high lock indication |

## Verification
The bench targets the run length exactly. It checks that the flag is still low after two or four good cycles and high after three or five. A design off by one in its run compare would lock a cycle early or late. It places errors exactly at each threshold. An error equal to the set threshold must break a run, and an error equal to the clear threshold must not unlock; a design using the wrong comparison edge would misjudge these cycles. It mixes cycles with both pulses high and with down-only errors, which catches a detector that counts either pulse rather than their disagreement. It interrupts runs with mid-size errors and with power-down, which exposes a run counter that is not cleared and locks early on the next run.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic accClr;   // empty the per-cycle error accumulator
    logic runInc;   // extend the consecutive-good run
    logic runClr;   // drop the consecutive-good run
  } ldStrobe_t;

  // judgement from datapath to control
  typedef struct packed {
    logic isGood;    // cycle error below the set threshold
    logic isBad;     // cycle error above the clear threshold
    logic runReach;  // this good cycle completes the required run
  } ldStatus_t;

  typedef enum logic {
    LD_UNLOCKED = 1'b0,
    LD_LOCKED   = 1'b1
  } ldState_e;

endpackage

// File: rtl/lockdet_datapath.sv
module lockdet_datapath
  import lockdet_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int RUN_W   = 3,
  parameter int GOOD_LO = 3,
  parameter int GOOD_HI = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upPulse,
  input  logic             dnPulse,
  input  logic             precSel,
  input  logic [CNT_W-1:0] setThresh,
  input  logic [CNT_W-1:0] clrThresh,
  input  ldStrobe_t        strobes,
  output ldStatus_t        status
);

  localparam logic [CNT_W-1:0] ERR_MAX = {CNT_W{1'b1}};
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};
  localparam logic [RUN_W-1:0] NEED_LO = RUN_W'(GOOD_LO - 1);
  localparam logic [RUN_W-1:0] NEED_HI = RUN_W'(GOOD_HI - 1);

  logic [CNT_W-1:0] errCnt;
  logic [CNT_W:0]   errSum;
  logic [CNT_W-1:0] errTotal;
  logic             diffNow;
  logic [RUN_W-1:0] runCnt;
  logic [RUN_W-1:0] needPrior;

  // error of the current cycle, including the present tick
  assign diffNow  = upPulse ^ dnPulse;
  assign errSum   = {1'b0, errCnt} + {{CNT_W{1'b0}}, diffNow};
  assign errTotal = errSum[CNT_W] ? ERR_MAX : errSum[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              errCnt <= '0;
    else if (strobes.accClr) errCnt <= '0;
    else                     errCnt <= errTotal;
  end

  // good cycles already banked before this one
  assign needPrior = precSel ? NEED_HI : NEED_LO;

  always_comb begin
    status.isGood   = (errTotal < setThresh);
    status.isBad    = (errTotal > clrThresh);
    status.runReach = (runCnt >= needPrior);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   runCnt <= '0;
    else if (strobes.runClr)      runCnt <= '0;
    else if (strobes.runInc && runCnt != RUN_MAX) runCnt <= runCnt + 1'b1;
  end

  assert_run_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.runClr |=> (runCnt == '0));

  assert_run_sat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.runInc && !strobes.runClr && runCnt == RUN_MAX) |=> (runCnt == RUN_MAX));

  assert_run_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.runInc && !strobes.runClr && runCnt != RUN_MAX) |=> (runCnt == $past(runCnt) + 1'b1));

endmodule

// File: rtl/lockdet_ctrl.sv
module lockdet_ctrl
  import lockdet_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pwrDown,
  input  logic      cycleStrobe,
  input  ldStatus_t status,
  output ldStrobe_t strobes,
  output logic      lockFlag
);

  ldState_e state, stateNext;

  always_comb begin
    strobes.accClr = pwrDown | cycleStrobe;
    strobes.runClr = pwrDown | (cycleStrobe & ~status.isGood);
    strobes.runInc = ~pwrDown & cycleStrobe & status.isGood;
  end

  always_comb begin
    stateNext = state;
    if (pwrDown) begin
      stateNext = LD_UNLOCKED;
    end else if (cycleStrobe) begin
      case (state)
        LD_UNLOCKED: if (status.isGood && status.runReach) stateNext = LD_LOCKED;
        LD_LOCKED:   if (status.isBad) stateNext = LD_UNLOCKED;
        default:     stateNext = LD_UNLOCKED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= LD_UNLOCKED;
    else        state <= stateNext;
  end

  assign lockFlag = (state == LD_LOCKED);

  assert_pwrdown_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pwrDown |=> !lockFlag);

  assert_lock_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lockFlag) |-> $past(cycleStrobe && status.isGood && status.runReach && !pwrDown));

  assert_bad_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cycleStrobe && status.isBad) |=> !lockFlag);

  assert_mid_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lockFlag && cycleStrobe && !status.isBad && !pwrDown) |=> lockFlag);

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cycleStrobe && !pwrDown) |=> $stable(lockFlag));

endmodule

// File: rtl/pfd_lock_monitor.sv
module pfd_lock_monitor
  import lockdet_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int RUN_W   = 3,
  parameter int GOOD_LO = 3,
  parameter int GOOD_HI = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwrDown,
  input  logic             upPulse,
  input  logic             dnPulse,
  input  logic             cycleStrobe,
  input  logic             precSel,
  input  logic [CNT_W-1:0] setThresh,
  input  logic [CNT_W-1:0] clrThresh,
  output logic             lockFlag
);

  ldStrobe_t strobes;
  ldStatus_t status;

  lockdet_datapath #(
    .CNT_W  (CNT_W),
    .RUN_W  (RUN_W),
    .GOOD_LO(GOOD_LO),
    .GOOD_HI(GOOD_HI)
  ) datapath_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .upPulse  (upPulse),
    .dnPulse  (dnPulse),
    .precSel  (precSel),
    .setThresh(setThresh),
    .clrThresh(clrThresh),
    .strobes  (strobes),
    .status   (status)
  );

  lockdet_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwrDown    (pwrDown),
    .cycleStrobe(cycleStrobe),
    .status     (status),
    .strobes    (strobes),
    .lockFlag   (lockFlag)
  );

endmodule

// File: tb/pfd_lock_monitor_tb_top.sv
module pfd_lock_monitor_tb_top;

  localparam int CNT_W = 8;
  localparam int CYC_LEN = 10;
  localparam int SET_T = 4;   // good: error 0..3
  localparam int CLR_T = 6;   // bad: error 7 and up

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwrDown = 1'b0;
  logic upPulse = 1'b0;
  logic dnPulse = 1'b0;
  logic cycleStrobe = 1'b0;
  logic precSel = 1'b0;
  logic [CNT_W-1:0] setThresh = CNT_W'(SET_T);
  logic [CNT_W-1:0] clrThresh = CNT_W'(CLR_T);
  logic lockFlag;

  always #4 clk = ~clk;

  pfd_lock_monitor #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwrDown(pwrDown),
    .upPulse(upPulse), .dnPulse(dnPulse), .cycleStrobe(cycleStrobe),
    .precSel(precSel), .setThresh(setThresh), .clrThresh(clrThresh),
    .lockFlag(lockFlag)
  );

  typedef struct {
    bit    exp;
    string tag;
  } expItem_t;

  expItem_t scoreQ[$];
  int total = 0;
  int bad = 0;
  bit modelLock = 1'b0;
  int modelRun = 0;

  task automatic check(input logic act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: lockFlag actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one comparison cycle: errTicks disagreeing ticks, then bothTicks with both high
  task automatic compCycle(input int errTicks, input int bothTicks, input bit useDn,
                           input string tag);
    int need;
    bit good, badc;
    for (int i = 0; i < CYC_LEN; i++) begin
      @(negedge clk);
      if (i == CYC_LEN - 2) check(lockFlag, modelLock, "R10 stable between strobes");
      if (i < errTicks) begin
        upPulse = ~useDn;
        dnPulse = useDn;
      end else if (i < errTicks + bothTicks) begin
        upPulse = 1'b1;
        dnPulse = 1'b1;
      end else begin
        upPulse = 1'b0;
        dnPulse = 1'b0;
      end
      cycleStrobe = (i == CYC_LEN - 1);
    end
    need = precSel ? 5 : 3;
    good = (errTicks < SET_T);
    badc = (errTicks > CLR_T);
    if (good) modelRun = (modelRun < 7) ? modelRun + 1 : 7;
    else      modelRun = 0;
    if (good && modelRun >= need) modelLock = 1'b1;
    if (badc) modelLock = 1'b0;
    scoreQ.push_back('{modelLock, tag});
    @(negedge clk);
    upPulse = 1'b0;
    dnPulse = 1'b0;
    cycleStrobe = 1'b0;
  endtask

  task automatic powerDownPulse();
    @(negedge clk);
    pwrDown = 1'b1;
    @(negedge clk);
    pwrDown = 1'b0;
    check(lockFlag, 1'b0, "R1 power-down clears flag");
    modelLock = 1'b0;
    modelRun = 0;
  endtask

  // monitor: compare flag after each strobe edge against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && cycleStrobe) begin
        @(negedge clk);
        if (scoreQ.size() == 0) begin
          total++;
          bad++;
          $display("FAIL scoreboard: strobe with no expected item, actual=%0b expected=none", lockFlag);
        end else begin
          expItem_t it;
          it = scoreQ.pop_front();
          check(lockFlag, it.exp, it.tag);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(lockFlag, 1'b0, "R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check(lockFlag, 1'b0, "R1 after reset release");

    // R4: three good cycles in normal precision
    precSel = 1'b0;
    compCycle(0, 0, 1'b0, "R4 first good");
    compCycle(3, 0, 1'b0, "R3 R4 second good at set-1");
    compCycle(2, 0, 1'b1, "R4 third good sets");
    // R8: mid errors hold the lock
    compCycle(5, 0, 1'b0, "R8 mid error holds");
    compCycle(6, 0, 1'b1, "R8 error equal to clear threshold holds");
    // R9: long good run keeps lock
    for (int k = 0; k < 10; k++) compCycle(1, 0, 1'b0, "R9 saturated run keeps lock");
    // R7: one large error clears
    compCycle(7, 0, 1'b0, "R7 large error clears");

    // R6: run broken by error equal to set threshold
    compCycle(0, 0, 1'b1, "R6 good 1");
    compCycle(1, 0, 1'b1, "R6 good 2");
    compCycle(4, 0, 1'b1, "R6 error equal to set threshold breaks run");
    compCycle(0, 0, 1'b1, "R6 restart 1");
    compCycle(0, 0, 1'b1, "R6 restart 2");
    compCycle(3, 0, 1'b1, "R6 restart 3 sets");

    // R2: both-high ticks do not count as error
    compCycle(8, 0, 1'b0, "R7 clear before R2");
    compCycle(0, 9, 1'b0, "R2 both high is good 1");
    compCycle(2, 7, 1'b1, "R2 both high is good 2");
    compCycle(0, 8, 1'b0, "R2 both high is good 3 sets");

    // R5: five cycles in high precision
    compCycle(9, 0, 1'b0, "R7 clear before R5");
    precSel = 1'b1;
    compCycle(0, 0, 1'b0, "R5 good 1");
    compCycle(3, 5, 1'b0, "R5 good 2");
    compCycle(1, 0, 1'b1, "R5 good 3");
    compCycle(0, 4, 1'b0, "R5 good 4 still unlocked");
    compCycle(2, 0, 1'b0, "R5 good 5 sets");

    // R1: power-down clears flag and run
    powerDownPulse();
    compCycle(0, 0, 1'b0, "R1 after power-down 1");
    compCycle(0, 0, 1'b0, "R1 after power-down 2");
    compCycle(0, 0, 1'b0, "R1 after power-down 3");
    compCycle(0, 0, 1'b0, "R1 after power-down 4");
    compCycle(0, 0, 1'b0, "R1 R5 after power-down 5 sets");

    // R6: interrupted high-precision run
    compCycle(8, 0, 1'b1, "R7 clear before interrupted run");
    for (int k = 0; k < 4; k++) compCycle(0, 0, 1'b0, "R6 R5 first partial run");
    compCycle(5, 0, 1'b0, "R6 mid error interrupts");
    for (int k = 0; k < 4; k++) compCycle(1, 0, 1'b0, "R6 R5 second partial run");
    compCycle(0, 0, 1'b0, "R6 R5 fifth good after interruption sets");

    // R1: power-down while locked in normal precision, then short run
    precSel = 1'b0;
    powerDownPulse();
    compCycle(0, 0, 1'b0, "R1 R4 post power-down 1");
    compCycle(0, 0, 1'b0, "R1 R4 post power-down 2");
    compCycle(0, 0, 1'b0, "R1 R4 post power-down 3 sets");

    wait (scoreQ.size() == 0);
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule